// File: doc/BRIEF.md
# Pipelined Core-to-Bank Request Crossbar

This block carries requests from eight processor cores to nine destinations: eight cache banks and one unit for non-cacheable accesses. Each core offers one request per cycle. A request carries a destination index and a payload. Every pairing of a core with a destination owns a private two-entry queue. Because of this, a core that is stalled toward one busy bank can still send to any other bank. Each destination runs its own round-robin choice among the cores that have something queued for it. All nine destinations work independently, so up to nine requests leave the fabric in one cycle.

A request moves through four stages. In the request stage it is written into its pair queue. In the arbitrate stage a grant is registered. In the select stage the granted queue head is chosen and popped. In the transmit stage the destination output register is loaded. A core learns that a pair queue is full from a dedicated ready bit for each core/destination pair. Destination indices 0 to 7 name the banks and index 8 names the non-cacheable unit.

Top module: `xbp_crossbar`

## Requirements
- R1: A request from core s is accepted at a clock edge when `src_valid[s]` is high, its 4-bit destination field `src_dest[s*4 +: 4]` holds a value d below 9, and `src_ready[s*9+d]` is high. Only accepted requests ever reach an output.
- R2: With no competing traffic, a request accepted at the edge ending cycle t appears on its destination in cycle t+3. It appears for exactly one cycle, with `dst_valid[d]` high, `dst_src[d*3 +: 3]` equal to the core index and `dst_payload[d*16 +: 16]` equal to the payload. In cycles t+1 and t+2 that output is not valid.
- R3: Each core/destination pair buffers at most two requests. `src_ready[s*9+d]` is low exactly while that pair holds two entries, and no accepted request is lost.
- R4: Requests from one core to one destination are delivered in the order they were accepted.
- R5: Each destination grants cores round-robin. After reset the search starts at core 0. After each grant it starts at the core one above the granted one, wrapping from 7 to 0.
- R6: Different destinations can each deliver a request from a different core in the same cycle.
- R7: A request whose destination field is 9 or above is discarded. It produces no output anywhere and does not lower any ready bit.
- R8: After reset every `dst_valid` bit is low and every `src_ready` bit is high. A destination with nothing queued or in flight keeps `dst_valid` low.
- R9: A destination with requests waiting delivers one request per cycle with no idle gap, including back-to-back requests from the same core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 8 | Request valid, one bit per core |
| src_dest | input | 32 | Destination index, 4 bits per core |
| src_payload | input | 128 | Request payload, 16 bits per core |
| src_ready | output | 72 | Pair-queue room, bit s*9+d for core s toward destination d |
| dst_valid | output | 9 | Output valid, one bit per destination |
| dst_src | output | 27 | Index of the delivering core, 3 bits per destination |
| dst_payload | output | 144 | Delivered payload, 16 bits per destination |

## Verification
Pair-queue state reaches the ports in two ways: through the ready bits in the same cycle, and through the delivered stream three cycles after an accept. A miscounted occupancy therefore shows as a ready bit that falls one request early or late, or as a lost or duplicated payload in the drain that follows. A wrong round-robin pointer shows within a few cycles as a permuted core order on a contended destination. The tests are built so that a fixed-priority order and a pointer that does not advance past the winner both produce different sequences. A slip in the pipeline shows as the first valid output arriving off the t+3 cycle. Stale grant bookkeeping shows as a gap or a repeated core in a back-to-back drain.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

   // Width of an index able to address n distinct items (at least one bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Queue implementation chosen from the requested depth.
   typedef enum logic [0:0] {
      QK_SINGLE = 1'b0,
      QK_RING   = 1'b1
   } queue_kind_e;

   function automatic queue_kind_e pick_queue_kind(input int unsigned depth);
      return (depth == 1) ? QK_SINGLE : QK_RING;
   endfunction

endpackage

// File: rtl/xbp_pair_fifo.sv
module xbp_pair_fifo
   import xbp_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CW   = idx_w(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] occ
);

   localparam queue_kind_e KIND = pick_queue_kind(DEPTH);

   generate
      if (KIND == QK_SINGLE) begin : g_single
         logic [W-1:0] slot_q;
         logic         full_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q <= 1'b0;
            end else if (push) begin
               full_q <= 1'b1;
            end else if (pop) begin
               full_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push) begin
               slot_q <= push_data;
            end
         end

         assign head = slot_q;
         assign occ  = CW'(full_q);
      end else begin : g_ring
         localparam int unsigned PW = idx_w(DEPTH);
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

         logic [W-1:0]  store_q [DEPTH];
         logic [PW-1:0] wr_q;
         logic [PW-1:0] rd_q;
         logic [CW-1:0] cnt_q;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == LAST) ? '0 : p + PW'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) begin
                  wr_q <= step(wr_q);
               end
               if (pop) begin
                  rd_q <= step(rd_q);
               end
               case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + CW'(1);
                  2'b01:   cnt_q <= cnt_q - CW'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push) begin
               store_q[wr_q] <= push_data;
            end
         end

         assign head = store_q[rd_q];
         assign occ  = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/xbp_rr_pick.sv
module xbp_rr_pick
   import xbp_pkg::*;
#(
   parameter int unsigned N  = 8,
   localparam int unsigned IW = idx_w(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          any,
   output logic [IW-1:0] win
);

   // Scan from the highest offset down so the lowest offset from start wins.
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int k = N - 1; k >= 0; k--) begin
         int t;
         t = int'(start) + k;
         if (t >= int'(N)) begin
            t = t - int'(N);
         end
         if (req[t]) begin
            any = 1'b1;
            win = IW'(t);
         end
      end
   end

endmodule

// File: rtl/xbp_dest_lane.sv
module xbp_dest_lane
   import xbp_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned SW   = idx_w(N_SRC),
   localparam int unsigned CW   = idx_w(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0][CW-1:0]   occ,
   input  logic [N_SRC-1:0][W-1:0]    head,
   output logic [N_SRC-1:0]           pop,
   output logic                       out_v,
   output logic [SW-1:0]              out_src,
   output logic [W-1:0]               out_data
);

   localparam logic [SW-1:0] TOP_SRC = SW'(N_SRC - 1);

   logic [N_SRC-1:0] avail;
   logic             pick_any;
   logic [SW-1:0]    pick_win;
   logic             gnt_v_q;
   logic [SW-1:0]    gnt_src_q;
   logic [SW-1:0]    ptr_q;

   // Arbitrate stage: an entry already granted but not yet popped is not
   // offered again, so a source needs a second entry to win twice in a row.
   always_comb begin
      for (int s = 0; s < N_SRC; s++) begin
         if (gnt_v_q && (gnt_src_q == SW'(s))) begin
            avail[s] = (occ[s] > CW'(1));
         end else begin
            avail[s] = (occ[s] != '0);
         end
      end
   end

   xbp_rr_pick #(.N(N_SRC)) u_pick (
      .req   (avail),
      .start (ptr_q),
      .any   (pick_any),
      .win   (pick_win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_v_q   <= 1'b0;
         gnt_src_q <= '0;
         ptr_q     <= '0;
      end else begin
         gnt_v_q <= pick_any;
         if (pick_any) begin
            gnt_src_q <= pick_win;
            ptr_q     <= (pick_win == TOP_SRC) ? '0 : pick_win + SW'(1);
         end
      end
   end

   // Select stage: the granted head is muxed out and its queue is popped.
   always_comb begin
      for (int s = 0; s < N_SRC; s++) begin
         pop[s] = gnt_v_q && (gnt_src_q == SW'(s));
      end
   end

   // Transmit stage: destination output register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v   <= 1'b0;
         out_src <= '0;
      end else begin
         out_v <= gnt_v_q;
         if (gnt_v_q) begin
            out_src <= gnt_src_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (gnt_v_q) begin
         out_data <= head[gnt_src_q];
      end
   end

endmodule

// File: rtl/xbp_crossbar.sv
module xbp_crossbar
   import xbp_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned N_DST = 9,
   parameter int unsigned DEPTH = 2,
   parameter int unsigned PAY_W = 16,
   parameter int unsigned DW    = 4,
   localparam int unsigned SW   = idx_w(N_SRC),
   localparam int unsigned CW   = idx_w(DEPTH + 1),
   localparam int unsigned NP   = N_SRC * N_DST
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        src_valid,
   input  logic [N_SRC*DW-1:0]     src_dest,
   input  logic [N_SRC*PAY_W-1:0]  src_payload,
   output logic [NP-1:0]           src_ready,
   output logic [N_DST-1:0]        dst_valid,
   output logic [N_DST*SW-1:0]     dst_src,
   output logic [N_DST*PAY_W-1:0]  dst_payload
);

   if (N_SRC < 2) begin : g_chk_src
      $error("xbp_crossbar: N_SRC must be at least 2");
   end
   if (N_DST < 1) begin : g_chk_dst
      $error("xbp_crossbar: N_DST must be at least 1");
   end
   if (DEPTH < 1) begin : g_chk_depth
      $error("xbp_crossbar: DEPTH must be at least 1");
   end
   if (PAY_W < 1) begin : g_chk_pay
      $error("xbp_crossbar: PAY_W must be at least 1");
   end
   if ((2 ** DW) < N_DST) begin : g_chk_dw
      $error("xbp_crossbar: DW too narrow for N_DST");
   end

   logic [N_DST-1:0][N_SRC-1:0][CW-1:0]    occ;
   logic [N_DST-1:0][N_SRC-1:0][PAY_W-1:0] head;
   logic [N_DST-1:0][N_SRC-1:0]            pop;

   // Request stage: one queue per source/destination pair.
   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         logic room;
         logic push;

         assign room = (occ[d][s] < CW'(DEPTH));
         assign push = src_valid[s] && (src_dest[s*DW +: DW] == DW'(d)) && room;
         assign src_ready[s*N_DST + d] = room;

         xbp_pair_fifo #(.W(PAY_W), .DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data (src_payload[s*PAY_W +: PAY_W]),
            .pop       (pop[d][s]),
            .head      (head[d][s]),
            .occ       (occ[d][s])
         );
      end

      // Arbitrate, select and transmit stages for this destination.
      xbp_dest_lane #(.N_SRC(N_SRC), .W(PAY_W), .DEPTH(DEPTH)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .occ      (occ[d]),
         .head     (head[d]),
         .pop      (pop[d]),
         .out_v    (dst_valid[d]),
         .out_src  (dst_src[d*SW +: SW]),
         .out_data (dst_payload[d*PAY_W +: PAY_W])
      );
   end

endmodule

// File: rtl/xbp_crossbar_sva.sv
module xbp_crossbar_sva
   import xbp_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned N_DST = 9,
   parameter int unsigned DEPTH = 2,
   parameter int unsigned DW    = 4,
   localparam int unsigned SW   = idx_w(N_SRC),
   localparam int unsigned CW   = idx_w(DEPTH + 1),
   localparam int unsigned NP   = N_SRC * N_DST
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [N_SRC-1:0]                  src_valid,
   input logic [N_SRC*DW-1:0]               src_dest,
   input logic [NP-1:0]                     src_ready,
   input logic [N_DST-1:0]                  dst_valid,
   input logic [N_DST*SW-1:0]               dst_src,
   input logic [N_DST-1:0][N_SRC-1:0][CW-1:0] occ
);

   logic [N_DST-1:0][N_SRC-1:0] busy;

   always_comb begin
      for (int d = 0; d < N_DST; d++) begin
         for (int s = 0; s < N_SRC; s++) begin
            busy[d][s] = (occ[d][s] != '0);
         end
      end
   end

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dst_valid == '0) && (&src_ready)); // R8

   for (genvar d = 0; d < N_DST; d++) begin : g_d
      for (genvar s = 0; s < N_SRC; s++) begin : g_s
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[d][s] == CW'(DEPTH)) |-> !src_ready[s*N_DST + d]); // R3

         AST_GROWTH_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[d][s] > $past(occ[d][s])) |->
               $past(src_valid[s] && (src_dest[s*DW +: DW] == DW'(d))
                     && src_ready[s*N_DST + d])); // R1
      end

      AST_OUTPUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         dst_valid[d] |-> $past(busy[d] != '0, 2)); // R8

      AST_RR_REPEAT_ONLY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
         (dst_valid[d] && $past(dst_valid[d])
            && (dst_src[d*SW +: SW] == $past(dst_src[d*SW +: SW]))) |->
         (($past(busy[d], 2) & ~(N_SRC'(1) << dst_src[d*SW +: SW])) == '0)); // R5
   end

endmodule

bind xbp_crossbar xbp_crossbar_sva #(
   .N_SRC (N_SRC),
   .N_DST (N_DST),
   .DEPTH (DEPTH),
   .DW    (DW)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_dest  (src_dest),
   .src_ready (src_ready),
   .dst_valid (dst_valid),
   .dst_src   (dst_src),
   .occ       (occ)
);

// File: tb/xbp_crossbar_test.sv
module xbp_crossbar_test;

   localparam int PERIOD = 10;
   localparam int NS = 8;
   localparam int ND = 9;
   localparam int DW = 4;
   localparam int SW = 3;
   localparam int PW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS-1:0]     src_valid = '0;
   logic [NS*DW-1:0]  src_dest = '0;
   logic [NS*PW-1:0]  src_payload = '0;
   logic [NS*ND-1:0]  src_ready;
   logic [ND-1:0]     dst_valid;
   logic [ND*SW-1:0]  dst_src;
   logic [ND*PW-1:0]  dst_payload;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   xbp_crossbar uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_valid   (src_valid),
      .src_dest    (src_dest),
      .src_payload (src_payload),
      .src_ready   (src_ready),
      .dst_valid   (dst_valid),
      .dst_src     (dst_src),
      .dst_payload (dst_payload)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      src_valid = '0;
      src_dest = '0;
      src_payload = '0;
   endtask

   task automatic put(input int s, input int d, input logic [PW-1:0] p);
      src_valid[s] = 1'b1;
      src_dest[s*DW +: DW] = DW'(d);
      src_payload[s*PW +: PW] = p;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic expect_out(input int d, input int s, input logic [PW-1:0] p,
                             input string req);
      chk(dst_valid[d] === 1'b1, {req, " valid"}, dst_valid, ND'(1) << d);
      chk(dst_src[d*SW +: SW] === SW'(s), {req, " source"}, dst_src[d*SW +: SW], s);
      chk(dst_payload[d*PW +: PW] === p, {req, " payload"}, dst_payload[d*PW +: PW], p);
   endtask

   task automatic test_reset();
      do_reset();
      chk(dst_valid === '0, "R8 reset valid", dst_valid, 0);
      chk(&src_ready, "R8 reset ready", src_ready, {NS*ND{1'b1}});
   endtask

   task automatic test_latency();
      do_reset();
      put(2, 5, 16'hA5C3);
      tick();
      idle_inputs();
      chk(dst_valid === '0, "R2 cycle t+1 quiet", dst_valid, 0);
      tick();
      chk(dst_valid === '0, "R2 cycle t+2 quiet", dst_valid, 0);
      tick();
      chk(dst_valid === ND'(1) << 5, "R2 only dest 5 valid at t+3", dst_valid, ND'(1) << 5);
      expect_out(5, 2, 16'hA5C3, "R2 t+3");
      tick();
      chk(dst_valid === '0, "R2 single cycle / R8 idle", dst_valid, 0);
   endtask

   task automatic test_parallel();
      do_reset();
      for (int s = 0; s < NS; s++) put(s, s + 1, 16'h0100 + PW'(s));
      tick();
      idle_inputs();
      repeat (2) tick();
      chk(dst_valid === 9'h1FE, "R6 all dests together", dst_valid, 9'h1FE);
      for (int s = 0; s < NS; s++) expect_out(s + 1, s, 16'h0100 + PW'(s), "R6");
   endtask

   task automatic test_round_robin();
      do_reset();
      put(1, 0, 16'h0301);
      put(3, 0, 16'h0303);
      put(6, 0, 16'h0306);
      tick();
      idle_inputs();
      repeat (2) tick();
      expect_out(0, 1, 16'h0301, "R5 first");
      tick();
      expect_out(0, 3, 16'h0303, "R5 second");
      tick();
      expect_out(0, 6, 16'h0306, "R5 third");
      // Pointer now at 7: core 7 must beat core 2.
      put(2, 0, 16'h0402);
      put(7, 0, 16'h0407);
      tick();
      idle_inputs();
      repeat (2) tick();
      expect_out(0, 7, 16'h0407, "R5 wrap order first");
      tick();
      expect_out(0, 2, 16'h0402, "R5 wrap order second");
   endtask

   task automatic test_fifo_order();
      do_reset();
      put(4, 3, 16'hBEEF);
      tick();
      put(4, 3, 16'hCAFE);
      tick();
      idle_inputs();
      tick();
      expect_out(3, 4, 16'hBEEF, "R4 older first");
      tick();
      expect_out(3, 4, 16'hCAFE, "R4 newer second / R9 no gap");
   endtask

   task automatic test_backpressure();
      do_reset();
      for (int s = 0; s < NS; s++) put(s, 1, PW'(s << 8));
      tick();
      for (int s = 0; s < NS; s++) begin
         chk(src_ready[s*ND + 1] === 1'b1, "R3 ready with one entry", src_ready[s*ND + 1], 1);
         put(s, 1, PW'((s << 8) | 1));
      end
      tick();
      for (int s = 0; s < NS; s++) begin
         chk(src_ready[s*ND + 1] === 1'b0, "R3 ready low when full", src_ready[s*ND + 1], 0);
         chk(src_ready[s*ND + 4] === 1'b1, "R3 other pair unaffected", src_ready[s*ND + 4], 1);
      end
      idle_inputs();
      tick();
      for (int k = 0; k < 2 * NS; k++) begin
         expect_out(1, k % NS, PW'(((k % NS) << 8) | (k / NS)), "R9 R3 drain");
         tick();
      end
      chk(dst_valid === '0, "R8 idle after drain", dst_valid, 0);
      chk(&src_ready, "R3 ready restored", src_ready, {NS*ND{1'b1}});
   endtask

   task automatic test_out_of_range();
      do_reset();
      put(0, 12, 16'h1111);
      put(5, 9, 16'h2222);
      tick();
      idle_inputs();
      for (int c = 0; c < 6; c++) begin
         chk(dst_valid === '0, "R7 no output for bad index", dst_valid, 0);
         chk(&src_ready, "R7 ready untouched", src_ready, {NS*ND{1'b1}});
         tick();
      end
      // A valid request from the same core still goes through (R1).
      put(0, 8, 16'h3333);
      tick();
      idle_inputs();
      repeat (2) tick();
      expect_out(8, 0, 16'h3333, "R1 accept to unit 8");
   endtask

   initial begin
      test_reset();
      test_latency();
      test_parallel();
      test_round_robin();
      test_fifo_order();
      test_backpressure();
      test_out_of_range();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule